// File: doc/BRIEF.md
# Calendar Time Counter with Daylight Saving

This block keeps time of day (seconds, minutes, hours) and a calendar (day of week, date of month, month). It advances once per one-second strobe. Internally every field is held as a plain binary count. The output bytes and the load bytes are translated on the way in and out. They use binary or BCD according to a data-mode input, and the hours use 12-hour or 24-hour form according to a second mode input. A change of either mode input takes effect on the outputs at once, without a clock edge.

Software writes all six fields at once through the load port. An inhibit input freezes the counter while software reads or writes the fields. With daylight saving enabled, the counter makes two automatic corrections, both tested when the clock reads 01:59:59:

- On the first Sunday of April, it jumps forward one hour.
- On the last Sunday of October, it falls back one hour, once only.

A one-bit memory of the fall-back stops the repeated hour from being rolled back a second time.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset the counter reads 00:00:00, with day of week 1, date 1 and month 1.
- R2: Each strobe (`tick` high for one cycle) adds one second. Second 59 wraps to 0 and carries into the minutes, minute 59 wraps and carries into the hours, and hour 23 wraps to 0. The new value appears at the outputs at the first rising edge that samples the strobe.
- R3: With `bin_mode` = 1, every output and load byte is a plain binary number. With `bin_mode` = 0, each byte is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: With `h24_mode` = 1, hours run 0..23. With `h24_mode` = 0, hours read 12, 1..11, and bit 7 is set for PM. The hour after 11 AM is 12 PM (0x92 in BCD), the hour after 12 PM is 1 PM (0x81), and the hour after 11 PM is 12 AM (0x12).
- R5: When 23:59:59 rolls over to midnight, the day of week steps 1..7 and then wraps to 1 (1 = Sunday), and the date advances.
- R6: The date wraps to 1 after the last day of the month: 30 for April, June, September and November, 31 for the other long months, and 28 for February, or 29 when `leap_year` = 1. Month 12 wraps to 1.
- R7: With `dst_en` = 1, on a Sunday in month 4 with a date of 7 or less, the strobe at 01:59:59 moves the counter to 03:00:00.
- R8: With `dst_en` = 1, on a Sunday in month 10 with a date of 25 or more, the strobe at 01:59:59 moves the counter to 01:00:00. This happens only the first time. A later pass through 01:59:59 goes on to 02:00:00. The memory of the fall-back is cleared only by the next midnight rollover; a load does not clear it.
- R9: No jump is made when `dst_en` = 0, on a day that is not Sunday, or when the date is outside the windows of R7 and R8.
- R10: While `hold` = 1, strobes change no field.
- R11: When `load_en` is high at a rising edge, all six fields take the load bytes, decoded under the current modes. A strobe in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second strobe, one cycle wide |
| hold | input | 1 | Freezes counting while high |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| leap_year | input | 1 | Gives February 29 days |
| load_en | input | 1 | Writes all load bytes into the counter |
| wr_sec | input | 8 | Seconds to load |
| wr_min | input | 8 | Minutes to load |
| wr_hour | input | 8 | Hours to load |
| wr_wday | input | 8 | Day of week to load |
| wr_mday | input | 8 | Date of month to load |
| wr_mon | input | 8 | Month to load |
| tod_sec | output | 8 | Seconds |
| tod_min | output | 8 | Minutes |
| tod_hour | output | 8 | Hours |
| cal_wday | output | 8 | Day of week |
| cal_mday | output | 8 | Date of month |
| cal_mon | output | 8 | Month |

## Verification
A strobe or a load changes the outputs at the first rising edge that samples it, and a daylight-saving jump lands at that same edge. A change of `bin_mode` or `h24_mode` alters the outputs combinationally, with no edge needed. The bench drives every input on a falling edge and holds it across exactly one rising edge. It then reads the outputs on the next falling edge, half a period after the update, and each expected value is one step from the value loaded just before. Strobes sent under `hold` are followed by a read of all fields before any further stimulus.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NF     = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HR_LAST   = 23;
  localparam int WDAY_LAST = 7;
  localparam int MON_LAST  = 12;
  localparam int SUNDAY    = 1;

  localparam int SPRING_MON     = 4;
  localparam int SPRING_DAY_MAX = 7;
  localparam int FALL_MON       = 10;
  localparam int FALL_DAY_MIN   = 25;
  localparam int CHECK_HR       = 1;
  localparam int SPRING_HR      = 3;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {1'b0, 3'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    return bin ? 7'(b) : from_bcd(b);
  endfunction

  function automatic logic [7:0] hour_out(input logic [6:0] hr, input logic h24,
                                          input logic bin);
    logic [6:0] h12;
    logic [7:0] b;
    if (h24) return enc_byte(hr, bin);
    if (hr == 7'd0)       h12 = 7'd12;
    else if (hr > 7'd12)  h12 = hr - 7'd12;
    else                  h12 = hr;
    b = enc_byte(h12, bin);
    return {(hr >= 7'd12), b[6:0]};
  endfunction

  function automatic logic [6:0] hour_in(input logic [7:0] b, input logic h24,
                                         input logic bin);
    logic [6:0] v;
    v = dec_byte({1'b0, b[6:0]}, bin);
    if (h24) return dec_byte(b, bin);
    if (v == 7'd12) v = 7'd0;
    return b[7] ? v + 7'd12 : v;
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                        return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:     return 5'd30;
      default:                     return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld,
  input  logic [5:0] ld_sec,
  input  logic [5:0] ld_min,
  input  logic [4:0] ld_hr,
  input  logic       spring_ok,
  input  logic       fall_ok,
  output logic [5:0] sec,
  output logic [5:0] min,
  output logic [4:0] hr,
  output logic       day_wrap,
  output logic       spring_jump,
  output logic       fall_jump,
  output logic       fb_done
);

  logic at_check, sec_wrap, min_wrap;

  assign at_check    = (hr == 5'(CHECK_HR)) && (min == 6'(MIN_LAST)) && (sec == 6'(SEC_LAST));
  assign spring_jump = step && at_check && spring_ok;
  assign fall_jump   = step && at_check && fall_ok && !fb_done;
  assign sec_wrap    = step && (sec >= 6'(SEC_LAST));
  assign min_wrap    = sec_wrap && (min >= 6'(MIN_LAST));
  assign day_wrap    = min_wrap && (hr >= 5'(HR_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0;
      min <= '0;
      hr  <= '0;
    end else if (ld) begin
      sec <= ld_sec;
      min <= ld_min;
      hr  <= ld_hr;
    end else if (spring_jump) begin
      sec <= '0;
      min <= '0;
      hr  <= 5'(SPRING_HR);
    end else if (fall_jump) begin
      sec <= '0;
      min <= '0;
      hr  <= 5'(CHECK_HR);
    end else if (step) begin
      sec <= sec_wrap ? 6'd0 : sec + 6'd1;
      if (sec_wrap) min <= min_wrap ? 6'd0 : min + 6'd1;
      if (min_wrap) hr  <= day_wrap ? 5'd0 : hr + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fb_done <= 1'b0;
    else if (fall_jump) fb_done <= 1'b1;
    else if (day_wrap)  fb_done <= 1'b0;
  end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_step,
  input  logic       ld,
  input  logic [2:0] ld_wday,
  input  logic [4:0] ld_mday,
  input  logic [3:0] ld_mon,
  input  logic       leap,
  output logic [2:0] wday,
  output logic [4:0] mday,
  output logic [3:0] mon
);

  logic month_end, year_end;

  assign month_end = mday >= month_days(mon, leap);
  assign year_end  = mon >= 4'(MON_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wday <= 3'd1;
      mday <= 5'd1;
      mon  <= 4'd1;
    end else if (ld) begin
      wday <= ld_wday;
      mday <= ld_mday;
      mon  <= ld_mon;
    end else if (day_step) begin
      wday <= (wday >= 3'(WDAY_LAST)) ? 3'd1 : wday + 3'd1;
      mday <= month_end ? 5'd1 : mday + 5'd1;
      if (month_end) mon <= year_end ? 4'd1 : mon + 4'd1;
    end
  end

endmodule

// File: rtl/rtc_port_map.sv
module rtc_port_map
  import rtc_cal_pkg::*;
(
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic [6:0] cur_v   [NF],
  input  logic [7:0] ld_byte [NF],
  output logic [7:0] out_byte[NF],
  output logic [6:0] ld_v    [NF]
);

  for (genvar i = 0; i < NF; i++) begin : g_f
    if (i == F_HR) begin : g_hr
      assign out_byte[i] = hour_out(cur_v[i], h24_mode, bin_mode);
      assign ld_v[i]     = hour_in(ld_byte[i], h24_mode, bin_mode);
    end else begin : g_pl
      assign out_byte[i] = enc_byte(cur_v[i], bin_mode);
      assign ld_v[i]     = dec_byte(ld_byte[i], bin_mode);
    end
  end

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       dst_en,
  input  logic       leap_year,
  input  logic       load_en,
  input  logic [7:0] wr_sec,
  input  logic [7:0] wr_min,
  input  logic [7:0] wr_hour,
  input  logic [7:0] wr_wday,
  input  logic [7:0] wr_mday,
  input  logic [7:0] wr_mon,
  output logic [7:0] tod_sec,
  output logic [7:0] tod_min,
  output logic [7:0] tod_hour,
  output logic [7:0] cal_wday,
  output logic [7:0] cal_mday,
  output logic [7:0] cal_mon
);

  logic       step, spring_ok, fall_ok, is_sunday;
  logic       day_wrap, spring_jump, fall_jump, fb_done;
  logic [5:0] sec_b, min_b;
  logic [4:0] hr_b;
  logic [2:0] wday_b;
  logic [4:0] mday_b;
  logic [3:0] mon_b;

  logic [6:0] cur_v   [NF];
  logic [7:0] ld_byte [NF];
  logic [7:0] out_byte[NF];
  logic [6:0] ld_v    [NF];

  assign step      = tick && !hold && !load_en;
  assign is_sunday = wday_b == 3'(SUNDAY);
  assign spring_ok = dst_en && is_sunday && (mon_b == 4'(SPRING_MON))
                     && (mday_b <= 5'(SPRING_DAY_MAX));
  assign fall_ok   = dst_en && is_sunday && (mon_b == 4'(FALL_MON))
                     && (mday_b >= 5'(FALL_DAY_MIN));

  assign ld_byte[F_SEC]  = wr_sec;
  assign ld_byte[F_MIN]  = wr_min;
  assign ld_byte[F_HR]   = wr_hour;
  assign ld_byte[F_WDAY] = wr_wday;
  assign ld_byte[F_MDAY] = wr_mday;
  assign ld_byte[F_MON]  = wr_mon;

  assign cur_v[F_SEC]  = {1'b0, sec_b};
  assign cur_v[F_MIN]  = {1'b0, min_b};
  assign cur_v[F_HR]   = {2'b0, hr_b};
  assign cur_v[F_WDAY] = {4'b0, wday_b};
  assign cur_v[F_MDAY] = {2'b0, mday_b};
  assign cur_v[F_MON]  = {3'b0, mon_b};

  rtc_port_map u_map (
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .cur_v    (cur_v),
    .ld_byte  (ld_byte),
    .out_byte (out_byte),
    .ld_v     (ld_v)
  );

  rtc_time_chain u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .ld          (load_en),
    .ld_sec      (6'(ld_v[F_SEC])),
    .ld_min      (6'(ld_v[F_MIN])),
    .ld_hr       (5'(ld_v[F_HR])),
    .spring_ok   (spring_ok),
    .fall_ok     (fall_ok),
    .sec         (sec_b),
    .min         (min_b),
    .hr          (hr_b),
    .day_wrap    (day_wrap),
    .spring_jump (spring_jump),
    .fall_jump   (fall_jump),
    .fb_done     (fb_done)
  );

  rtc_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_wrap),
    .ld       (load_en),
    .ld_wday  (3'(ld_v[F_WDAY])),
    .ld_mday  (5'(ld_v[F_MDAY])),
    .ld_mon   (4'(ld_v[F_MON])),
    .leap     (leap_year),
    .wday     (wday_b),
    .mday     (mday_b),
    .mon      (mon_b)
  );

  assign tod_sec  = out_byte[F_SEC];
  assign tod_min  = out_byte[F_MIN];
  assign tod_hour = out_byte[F_HR];
  assign cal_wday = out_byte[F_WDAY];
  assign cal_mday = out_byte[F_MDAY];
  assign cal_mon  = out_byte[F_MON];

endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold,
  input logic       load_en,
  input logic       dst_en,
  input logic       step,
  input logic [5:0] sec_b,
  input logic [5:0] min_b,
  input logic [4:0] hr_b,
  input logic [2:0] wday_b,
  input logic       day_wrap,
  input logic       spring_jump,
  input logic       fall_jump,
  input logic       fb_done
);

  // R10: inhibit freezes every counting field
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !load_en |=> $stable(sec_b) && $stable(min_b) && $stable(hr_b) && $stable(wday_b));

  // R2: an ordinary strobe adds one second
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step && (sec_b < 6'd59) |=> sec_b == $past(sec_b) + 6'd1);

  // R5: weekday wraps from 7 to 1 at midnight
  p_wday_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap && (wday_b == 3'd7) |=> wday_b == 3'd1);

  // R7: forward jump lands on 03:00:00
  p_spring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spring_jump |=> (hr_b == 5'd3) && (min_b == 6'd0) && (sec_b == 6'd0));

  // R8: fall-back lands on 01:00:00 and is remembered
  p_fall_land_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_jump |=> fb_done && (hr_b == 5'd1) && (min_b == 6'd0) && (sec_b == 6'd0));

  // R8: no second fall-back while remembered
  p_fall_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_done |-> !fall_jump);

  // R9: no jumps with daylight saving disabled
  p_dst_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_en |-> !spring_jump && !fall_jump);

endmodule

bind rtc_cal_core rtc_cal_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold        (hold),
  .load_en     (load_en),
  .dst_en      (dst_en),
  .step        (step),
  .sec_b       (sec_b),
  .min_b       (min_b),
  .hr_b        (hr_b),
  .wday_b      (wday_b),
  .day_wrap    (day_wrap),
  .spring_jump (spring_jump),
  .fall_jump   (fall_jump),
  .fb_done     (fb_done)
);

// File: tb/rtc_cal_core_test.sv
`timescale 1ns/1ps
module rtc_cal_core_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, hold = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic dst_en = 1'b0, leap_year = 1'b0, load_en = 1'b0;
  logic [7:0] wr_sec = '0, wr_min = '0, wr_hour = '0, wr_wday = '0, wr_mday = '0, wr_mon = '0;
  logic [7:0] tod_sec, tod_min, tod_hour, cal_wday, cal_mday, cal_mon;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_cal_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold), .bin_mode(bin_mode),
    .h24_mode(h24_mode), .dst_en(dst_en), .leap_year(leap_year), .load_en(load_en),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_wday(wr_wday),
    .wr_mday(wr_mday), .wr_mon(wr_mon),
    .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
    .cal_wday(cal_wday), .cal_mday(cal_mday), .cal_mon(cal_mon)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input logic [7:0] h, input logic [7:0] m,
                          input logic [7:0] s);
    chk(req, "hour", tod_hour, h);
    chk(req, "min", tod_min, m);
    chk(req, "sec", tod_sec, s);
  endtask

  task automatic chk_date(input string req, input logic [7:0] wd, input logic [7:0] md,
                          input logic [7:0] mo);
    chk(req, "wday", cal_wday, wd);
    chk(req, "mday", cal_mday, md);
    chk(req, "mon", cal_mon, mo);
  endtask

  task automatic load_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] wd, input logic [7:0] md, input logic [7:0] mo);
    @(negedge clk);
    wr_sec = s; wr_min = m; wr_hour = h; wr_wday = wd; wr_mday = md; wr_mon = mo;
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    chk_time("R1", 8'h00, 8'h00, 8'h00);
    chk_date("R1", 8'h01, 8'h01, 8'h01);
  endtask

  task automatic t_carry();
    load_all(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12);
    pulse_tick();
    chk_time("R2", 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_time("R2", 8'h00, 8'h00, 8'h00);
    chk_date("R5", 8'h01, 8'h01, 8'h01);
    load_all(8'h59, 8'h09, 8'h05, 8'h03, 8'h10, 8'h06);
    pulse_tick();
    chk_time("R2", 8'h05, 8'h10, 8'h00);
    chk_date("R5", 8'h03, 8'h10, 8'h06);
  endtask

  task automatic t_binary();
    bin_mode = 1'b1;
    load_all(8'd59, 8'd59, 8'd13, 8'd3, 8'd15, 8'd6);
    pulse_tick();
    chk_time("R3", 8'd14, 8'd0, 8'd0);
    @(negedge clk);
    bin_mode = 1'b0;
    @(negedge clk);
    chk("R3", "bcd view hour", tod_hour, 8'h14);
    chk("R3", "bcd view mday", cal_mday, 8'h15);
  endtask

  task automatic t_12h();
    h24_mode = 1'b0;
    load_all(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h05);
    pulse_tick();
    chk_time("R4", 8'h92, 8'h00, 8'h00);
    load_all(8'h59, 8'h59, 8'h92, 8'h01, 8'h10, 8'h05);
    pulse_tick();
    chk("R4", "1 PM", tod_hour, 8'h81);
    load_all(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h05);
    pulse_tick();
    chk("R4", "12 AM", tod_hour, 8'h12);
    chk("R5", "wday after midnight", cal_wday, 8'h03);
    chk("R5", "mday after midnight", cal_mday, 8'h11);
    bin_mode = 1'b1;
    load_all(8'd0, 8'd0, 8'h8B, 8'd1, 8'd1, 8'd1);
    chk("R4", "binary 11 PM", tod_hour, 8'h8B);
    @(negedge clk);
    h24_mode = 1'b1;
    @(negedge clk);
    chk("R4", "11 PM as 24h", tod_hour, 8'd23);
    bin_mode = 1'b0;
  endtask

  task automatic month_case(input logic lp, input logic [7:0] md, input logic [7:0] mo,
                            input logic [7:0] emd, input logic [7:0] emo);
    leap_year = lp;
    load_all(8'h59, 8'h59, 8'h23, 8'h04, md, mo);
    pulse_tick();
    chk("R6", "mday", cal_mday, emd);
    chk("R6", "mon", cal_mon, emo);
  endtask

  task automatic t_month();
    month_case(1'b0, 8'h28, 8'h02, 8'h01, 8'h03);
    month_case(1'b1, 8'h28, 8'h02, 8'h29, 8'h02);
    month_case(1'b1, 8'h29, 8'h02, 8'h01, 8'h03);
    month_case(1'b0, 8'h30, 8'h04, 8'h01, 8'h05);
    month_case(1'b0, 8'h30, 8'h01, 8'h31, 8'h01);
    month_case(1'b0, 8'h31, 8'h12, 8'h01, 8'h01);
    leap_year = 1'b0;
  endtask

  task automatic t_spring();
    dst_en = 1'b1;
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04);
    pulse_tick();
    chk_time("R7", 8'h03, 8'h00, 8'h00);
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h07, 8'h04);
    pulse_tick();
    chk("R7", "date 7 edge", tod_hour, 8'h03);
  endtask

  task automatic t_dst_off();
    dst_en = 1'b0;
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04);
    pulse_tick();
    chk("R9", "disabled", tod_hour, 8'h02);
    dst_en = 1'b1;
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h08, 8'h04);
    pulse_tick();
    chk("R9", "date 8", tod_hour, 8'h02);
    load_all(8'h59, 8'h59, 8'h01, 8'h02, 8'h05, 8'h04);
    pulse_tick();
    chk("R9", "not Sunday", tod_hour, 8'h02);
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h24, 8'h10);
    pulse_tick();
    chk("R9", "Oct date 24", tod_hour, 8'h02);
  endtask

  task automatic t_fall();
    dst_en = 1'b1;
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10);
    pulse_tick();
    chk_time("R8", 8'h01, 8'h00, 8'h00);
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h28, 8'h10);
    pulse_tick();
    chk_time("R8", 8'h02, 8'h00, 8'h00);
    load_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h10);
    pulse_tick();
    chk_date("R8", 8'h02, 8'h29, 8'h10);
    load_all(8'h59, 8'h59, 8'h01, 8'h01, 8'h25, 8'h10);
    pulse_tick();
    chk("R8", "after midnight", tod_hour, 8'h01);
    chk("R8", "after midnight min", tod_min, 8'h00);
  endtask

  task automatic t_hold();
    load_all(8'h30, 8'h20, 8'h10, 8'h05, 8'h12, 8'h08);
    @(negedge clk);
    hold = 1'b1;
    for (int i = 0; i < 3; i++) pulse_tick();
    chk_time("R10", 8'h10, 8'h20, 8'h30);
    chk_date("R10", 8'h05, 8'h12, 8'h08);
    hold = 1'b0;
    pulse_tick();
    chk("R10", "released", tod_sec, 8'h31);
  endtask

  task automatic t_load_prio();
    @(negedge clk);
    wr_sec = 8'h44; wr_min = 8'h33; wr_hour = 8'h22; wr_wday = 8'h06;
    wr_mday = 8'h19; wr_mon = 8'h11;
    load_en = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    tick = 1'b0;
    chk_time("R11", 8'h22, 8'h33, 8'h44);
    chk_date("R11", 8'h06, 8'h19, 8'h11);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry();
    t_binary();
    t_12h();
    t_month();
    t_spring();
    t_dst_off();
    t_fall();
    t_hold();
    t_load_prio();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule